// File: doc/BRIEF.md
# UART Register Front-End with Receive Byte Queue

This block is the register face of a small serial port, attached to an APB slave port. Software sees a data register, a read-only status word and a fully writable control word. Bytes arriving on a byte-stream input with a valid/ready handshake are queued in a receive FIFO. Software reads them one at a time through the data register. A write to the data register goes straight out on a byte-stream output. Because of this write-through, the status word always reports the transmit side as empty.

A single interrupt line pulses for one clock cycle on every accepted receive byte and on every transmitted write, and each of the two sources has its own enable bit in the control word. The receive queue does not reuse its slots as a ring. It fills from slot zero, and it returns to slot zero only once software has read every stored byte. The queue therefore holds at most FIFO_DEPTH bytes between two drains.

Top module: `uart_regfront`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0000_0000 and the status word reads 0x0000_0006 (bit1 and bit2 set). The receive queue is empty, and irq, tx_valid and rx_ready are low.
- R2: The control word at offset 0x08 stores all 32 bits of a write and returns them unchanged on read.
- R3: Offsets 0x0C and 0x10 read as zero and ignore writes. Any offset that is not decoded also reads as zero. A write to the status word at 0x04 changes nothing.
- R4: A byte is taken from the input stream only while control bit0 (receive enable) is 1. rx_ready is low while this bit is 0 or the queue is full.
- R5: A read at offset 0x00 or 0x03 removes the oldest unread byte and returns it in prdata[7:0] with the upper bits zero. A read of an empty queue returns zero.
- R6: Status bit0 (data ready) is set when a byte is accepted. It is cleared by the read that removes the last unread byte, or by a read of an empty queue.
- R7: When the last unread byte is read, the queue returns to empty. Its capacity counts the bytes accepted since then, not the bytes still unread. Status bit10 shows that FIFO_DEPTH bytes have been accepted since the last drain. Status bit8 shows that at least FIFO_DEPTH/2 bytes have been accepted since the last drain.
- R8: A write at offset 0x00 or 0x03 with control bit1 (transmit enable) set places pwdata[7:0] on tx_data and holds tx_valid high until tx_ready is seen. With bit1 clear, the write sends nothing. A new write while a byte is still pending replaces that byte.
- R9: irq is high for one cycle in the cycle after a byte is accepted while control bit2 is set. It is also high for one cycle in the cycle after a data write while control bits 1 and 3 are both set. With the gating bits clear, irq stays low.
- R10: Every APB transfer completes with zero wait states, because pready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 5 | Byte offset within the register window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant high |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. With that depth, four pushes reach the full condition. Three pushes cross the half mark. A partly read but not drained queue then shows that capacity is not reclaimed until the last byte goes. The byte width stays at its default of 8, so data reads exercise the zero upper bits of prdata.

// File: rtl/uart_regfront_pkg.sv
// Package: register offsets, bit positions and the register-select type
// shared by the decoder and the top level.
package uart_regfront_pkg;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFF_DATA   = 5'h00;
    localparam logic [REG_AW-1:0] OFF_DATA_B = 5'h03;
    localparam logic [REG_AW-1:0] OFF_STAT   = 5'h04;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 5'h08;
    localparam logic [REG_AW-1:0] OFF_SCALE  = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_DBG    = 5'h10;

    localparam int CB_RXEN  = 0;
    localparam int CB_TXEN  = 1;
    localparam int CB_RXIRQ = 2;
    localparam int CB_TXIRQ = 3;

    localparam int SB_DREADY = 0;
    localparam int SB_TSHIFT = 1;
    localparam int SB_TQUEUE = 2;
    localparam int SB_RHALF  = 8;
    localparam int SB_RFULL  = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL,
        SEL_ZERO
    } reg_sel_e;
endpackage

// File: rtl/uart_addr_decode.sv
// Module: uart_addr_decode
// Maps a byte offset onto a register select. Purely combinational.
// Assumes the offset is already limited to the register window width.
module uart_addr_decode
    import uart_regfront_pkg::*;
(
    input  logic [REG_AW-1:0] offset,
    output reg_sel_e          sel
);
    // Offset to register select
    always_comb begin
        unique case (offset)
            OFF_DATA, OFF_DATA_B: sel = SEL_DATA;
            OFF_STAT:             sel = SEL_STAT;
            OFF_CTRL:             sel = SEL_CTRL;
            OFF_SCALE, OFF_DBG:   sel = SEL_ZERO;
            default:              sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Receive queue that fills from slot zero. A push writes at the fill
// level. A pop reads at the read index. When the pop removes the last
// unread byte, both counters return to zero; a push in that same cycle
// lands in slot zero. Assumes push is only raised while full is low.
// DEPTH must be at least 2.
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          half,
    output logic          dready
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
    localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);

    logic [DW-1:0] mem [DEPTH];
    logic [LW-1:0] lvl;
    logic [LW-1:0] rd;
    logic          have;
    logic          last;
    logic [PW-1:0] wr_idx;

    // Queue condition flags
    always_comb begin
        have   = rd < lvl;
        last   = pop && have && ((rd + LW'(1)) == lvl);
        wr_idx = last ? '0 : lvl[PW-1:0];
    end

    assign rd_data = have ? mem[rd[PW-1:0]] : '0;
    assign full    = lvl == DEPTH_L;
    assign half    = lvl >= HALF_L;

    // Byte storage, written on push
    always_ff @(posedge clk) begin
        if (push) mem[wr_idx] <= push_data;
    end

    // Fill level, read index and data-ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl    <= '0;
            rd     <= '0;
            dready <= 1'b0;
        end else begin
            if (last) begin
                rd  <= '0;
                lvl <= push ? LW'(1) : '0;
            end else begin
                if (pop && have) rd <= rd + LW'(1);
                if (push) lvl <= lvl + LW'(1);
            end
            if (push)
                dready <= 1'b1;
            else if (pop && (last || !have))
                dready <= 1'b0;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= DEPTH_L);
    a_r7_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        dready == (rd < lvl));
    a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !push) |=> (lvl == '0 && rd == '0));
endmodule

// File: rtl/uart_tx_irq.sv
// Module: uart_tx_irq
// Holds the outgoing byte until the sink takes it, and registers the
// one-cycle interrupt pulse from the receive and transmit events.
// Assumes data_wr is a single-cycle strobe from the APB access phase.
module uart_tx_irq #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tx_en,
    input  logic          tx_irq_en,
    input  logic          rx_accept,
    input  logic          rx_irq_en,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          irq
);
    logic tx_load;

    assign tx_load = data_wr && tx_en;

    // Outgoing byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (tx_load) begin
            tx_valid <= 1'b1;
            tx_data  <= wdata;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // Interrupt pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (rx_accept && rx_irq_en) || (tx_load && tx_irq_en);
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_load) |=> (tx_valid && $stable(tx_data)));
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !tx_load) |=> !tx_valid);
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_accept || data_wr));
endmodule

// File: rtl/uart_regfront.sv
// Module: uart_regfront (top)
// APB register front-end of a UART. It decodes the 5-bit offset, keeps
// the control word and builds the status word. It steers pops and pushes
// to the receive queue, and hands data writes to the transmit/interrupt
// stage. Assumes a well-formed APB master; all transfers take zero wait
// states.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8,
    parameter int APB_DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    output logic              pready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);
    reg_sel_e          sel;
    logic [APB_DW-1:0] ctrl_q;
    logic [APB_DW-1:0] status;
    logic              acc_wr;
    logic              acc_rd;
    logic              data_wr;
    logic              pop;
    logic              rx_accept;
    logic [DATA_W-1:0] q_data;
    logic              q_full;
    logic              q_half;
    logic              q_dready;

    uart_addr_decode u_dec (
        .offset (paddr),
        .sel    (sel)
    );

    // APB access-phase strobes
    always_comb begin
        acc_wr  = psel && penable && pwrite;
        acc_rd  = psel && penable && !pwrite;
        data_wr = acc_wr && (sel == SEL_DATA);
        pop     = acc_rd && (sel == SEL_DATA);
    end

    assign pready    = 1'b1;
    assign rx_ready  = ctrl_q[CB_RXEN] && !q_full;
    assign rx_accept = rx_valid && rx_ready;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (acc_wr && sel == SEL_CTRL)  ctrl_q <= pwdata;
    end

    uart_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (DATA_W)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_accept),
        .push_data (rx_data),
        .pop       (pop),
        .rd_data   (q_data),
        .full      (q_full),
        .half      (q_half),
        .dready    (q_dready)
    );

    uart_tx_irq #(
        .DW (DATA_W)
    ) u_txi (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .wdata     (pwdata[DATA_W-1:0]),
        .tx_en     (ctrl_q[CB_TXEN]),
        .tx_irq_en (ctrl_q[CB_TXIRQ]),
        .rx_accept (rx_accept),
        .rx_irq_en (ctrl_q[CB_RXIRQ]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    // Status word assembly
    always_comb begin
        status            = '0;
        status[SB_DREADY] = q_dready;
        status[SB_TSHIFT] = 1'b1;
        status[SB_TQUEUE] = 1'b1;
        status[SB_RHALF]  = q_half;
        status[SB_RFULL]  = q_full;
    end

    // Read data multiplexer
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (sel)
                SEL_DATA: prdata = APB_DW'(q_data);
                SEL_STAT: prdata = status;
                SEL_CTRL: prdata = ctrl_q;
                default:  prdata = '0;
            endcase
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && !irq && !tx_valid && !q_dready));
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && sel == SEL_CTRL) |=> $stable(ctrl_q));
    a_r4_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_RXEN] && !pop) |=> $stable(q_dready));
    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pready);
endmodule

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_regfront #(.FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
    endtask

    task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
    endtask

    // Drive one byte until accepted; returns 1 ns after the next falling edge
    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        for (int i = 0; i < 50; i++) begin
            #1;
            if (rx_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
    endtask

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0, 5'h04, 32'h0000_0006, 4'd1},  // R1 status reset value
        '{1'b0, 5'h08, 32'h0000_0000, 4'd1},  // R1 control reset value
        '{1'b1, 5'h08, 32'h8000_1FF0, 4'd2},  // R2 write control
        '{1'b0, 5'h08, 32'h8000_1FF0, 4'd2},  // R2 read back
        '{1'b1, 5'h04, 32'hFFFF_FFFF, 4'd3},  // R3 status write ignored
        '{1'b0, 5'h04, 32'h0000_0006, 4'd3},
        '{1'b1, 5'h0C, 32'h0000_1234, 4'd3},  // R3 scaler
        '{1'b0, 5'h0C, 32'h0000_0000, 4'd3},
        '{1'b1, 5'h10, 32'h0000_0055, 4'd3},  // R3 debug
        '{1'b0, 5'h10, 32'h0000_0000, 4'd3},
        '{1'b0, 5'h14, 32'h0000_0000, 4'd3},  // R3 undecoded
        '{1'b0, 5'h00, 32'h0000_0000, 4'd5},  // R5 empty read
        '{1'b1, 5'h08, 32'h0000_0000, 4'd2}
    };

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R10 output state after reset
        check("R1 rx_ready", {31'b0, rx_ready}, 32'd0);
        check("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R10 pready", {31'b0, pready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) apb_write(VT[i].addr, VT[i].val);
            else begin
                apb_read(VT[i].addr, r);
                check($sformatf("R%0d vec%0d", VT[i].req, i), r, VT[i].val);
            end
        end

        // R4: receive disabled, byte held off
        @(negedge clk);
        rx_data = 8'hA5; rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R4 ready low when disabled", {31'b0, rx_ready}, 32'd0);
        rx_valid = 1'b0;
        apb_write(5'h08, 32'h1);
        apb_read(5'h04, r);
        check("R4 nothing taken", r, 32'h6);

        // R9 no pulse with rx irq disabled
        rx_send(8'h77);
        check("R9 no irq when gated", {31'b0, irq}, 32'd0);
        apb_read(5'h00, r);
        check("R5 single byte", r, 32'h77);

        // R9 receive pulse
        apb_write(5'h08, 32'h5);
        rx_send(8'h11);
        check("R9 rx irq high", {31'b0, irq}, 32'd1);
        @(negedge clk); #1;
        check("R9 rx irq one cycle", {31'b0, irq}, 32'd0);
        rx_send(8'h22);
        rx_send(8'h33);
        apb_read(5'h04, r);
        check("R6 R7 status with 3 bytes", r, 32'h107);
        apb_read(5'h00, r);
        check("R5 order 1", r, 32'h11);
        apb_read(5'h03, r);
        check("R5 order 2 via 0x03", r, 32'h22);
        apb_read(5'h04, r);
        check("R6 still ready", r, 32'h107);
        apb_read(5'h00, r);
        check("R5 order 3", r, 32'h33);
        apb_read(5'h04, r);
        check("R6 R7 drained", r, 32'h6);
        apb_read(5'h00, r);
        check("R5 empty after drain", r, 32'h0);

        // R7 full, capacity not reclaimed until drained
        apb_write(5'h08, 32'h1);
        rx_send(8'h01); rx_send(8'h02); rx_send(8'h03); rx_send(8'h04);
        apb_read(5'h04, r);
        check("R7 full status", r, 32'h507);
        check("R7 ready low when full", {31'b0, rx_ready}, 32'd0);
        apb_read(5'h00, r);
        check("R5 first of full", r, 32'h01);
        check("R7 no reclaim after one read", {31'b0, rx_ready}, 32'd0);
        apb_read(5'h00, r); apb_read(5'h00, r); apb_read(5'h00, r);
        check("R5 last of full", r, 32'h04);
        check("R7 ready after drain", {31'b0, rx_ready}, 32'd1);
        apb_read(5'h04, r);
        check("R7 empty status", r, 32'h6);

        // R8 transmit with hold
        tx_ready = 1'b0;
        apb_write(5'h08, 32'h2);
        apb_write(5'h00, 32'h1C3);
        check("R8 tx_valid", {31'b0, tx_valid}, 32'd1);
        check("R8 tx_data", {24'b0, tx_data}, 32'hC3);
        check("R9 no tx irq when gated", {31'b0, irq}, 32'd0);
        repeat (3) @(negedge clk);
        #1 check("R8 held", {31'b0, tx_valid}, 32'd1);
        tx_ready = 1'b1;
        @(negedge clk); #1;
        check("R8 released", {31'b0, tx_valid}, 32'd0);

        // R8 transmit disabled
        apb_write(5'h08, 32'h8);
        apb_write(5'h03, 32'h5A);
        check("R8 no send when disabled", {31'b0, tx_valid}, 32'd0);
        check("R9 no irq without tx enable", {31'b0, irq}, 32'd0);

        // R9 transmit pulse
        apb_write(5'h08, 32'hA);
        apb_write(5'h03, 32'h3C);
        check("R9 tx irq high", {31'b0, irq}, 32'd1);
        check("R8 byte via 0x03", {24'b0, tx_data}, 32'h3C);
        @(negedge clk); #1;
        check("R9 tx irq one cycle", {31'b0, irq}, 32'd0);

        // R1 reset mid-run
        apb_write(5'h08, 32'h1);
        rx_send(8'h99);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        apb_read(5'h04, r);
        check("R1 status after reset", r, 32'h6);
        apb_read(5'h08, r);
        check("R1 control after reset", r, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule